// File: doc/BRIEF.md
# Programmable Horizontal Line Timing Sequencer

This block produces the horizontal timing of a raster display from a small writable flag memory rather than from fixed counters. Each memory entry is a 4-bit set of control flags that covers one nibble time (four pixel bits, one clock of this block). A read pointer walks the memory one entry per clock, and a small state machine turns the flags it reads into registered horizontal blank, horizontal sync, a mid-line marker and a line-restart pulse.

A host loads the table through a write port with a write-address register that increments after each strobe. While the table is being loaded, a force-blank control holds the display blanked and stops line restarts. The restart flag acts only while blanking is active. A table shorter than a line can therefore describe a longer line, because the pointer keeps wrapping through blanked entries until a restart flag is met.

The state machine has three states. ST_HOLD is forced blanking. ST_SCAN is the visible part of the line. ST_BLANK is horizontal blanking. Its transitions are:

- T_RELEASE: ST_HOLD to ST_SCAN, when force_blank is low.
- T_SETC: ST_SCAN to ST_BLANK, on a start-blank entry.
- T_SWITCH: ST_BLANK to ST_SCAN, on a restart entry.
- T_FORCE: any running state to ST_HOLD, when force_blank is high.

Reset enters ST_HOLD.

Top module: `hline_ctrl_seq`

## Requirements
- R1: A synchronous reset clears every flag entry to 0, sets the write address to 0, and enters ST_HOLD. After the reset edge, hblank=1 and hsync, midline and line_start are 0.
- R2: Each clock with wr_en high stores wr_data at the write address, and the address then increments modulo 256 (0xFF wraps to 0x00). When wr_addr_load is high, the address becomes wr_addr_val. A write in the same clock goes to wr_addr_val, and the following write goes to wr_addr_val+1.
- R3: While force_blank is sampled high, the next outputs are hblank=1, hsync=0, midline=0 and line_start=0, whatever the table holds. The read pointer is held at 0x68.
- R4: When force_blank is sampled low in ST_HOLD, line_start=1 and hblank=0 after that edge. The entry at 0x68 is reflected in the outputs after the following edge.
- R5: In ST_SCAN and ST_BLANK, the read pointer advances by one entry per clock and wraps from 0xFF to 0x00. The flags of the entry at pointer 0x68+k appear on the outputs k+1 edges after a line starts.
- R6: An entry with bit 3 (start blanking) set, read in ST_SCAN, drives hblank=1 for that entry and for every later entry until the line restarts.
- R7: An entry with bit 1 (restart) set, read in ST_BLANK, is itself blanked and gives a one-cycle line_start. The pointer reloads 0x68, and the next entry is shown with hblank=0.
- R8: A restart entry (bit 1) read in ST_SCAN is ignored: hblank stays 0, line_start stays 0 and the pointer keeps advancing.
- R9: Bit 2 of an entry drives hsync=1 only when that entry is blanked. In a visible entry, bit 2 leaves hsync at 0.
- R10: An entry with bit 0 set gives midline=1 for that entry's output cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock, one table entry per cycle |
| rst | input | 1 | Synchronous reset, active high |
| force_blank | input | 1 | Hold blanking and suspend line restart |
| wr_en | input | 1 | Write strobe for one flag entry |
| wr_addr_load | input | 1 | Load the write-address register |
| wr_addr_val | input | 8 | Value loaded into the write address |
| wr_data | input | 4 | Flag nibble to store |
| hblank | output | 1 | Horizontal blanking |
| hsync | output | 1 | Horizontal sync, only during blanking |
| midline | output | 1 | Mid-line marker pulse |
| line_start | output | 1 | One-cycle new-line pulse |

## Verification
Every output is a single register fed by the state machine, so each result is due exactly one edge after the stimulus or entry read that causes it. A release is seen after the edge that samples force_blank low. The entry at 0x68+k is seen k+1 edges after that release edge. The bench drives inputs and samples outputs on the falling edge, and steps one rising edge per comparison. Expected values come from a hand-derived line table indexed by the edge count since release, which holds the cycle accounting fixed.

// File: rtl/hline_ctrl_pkg.sv
`timescale 1ns/1ps
package hline_ctrl_pkg;
    localparam int FLAG_W   = 4;
    localparam int BIT_MID  = 0;
    localparam int BIT_SWT  = 1;
    localparam int BIT_SYNC = 2;
    localparam int BIT_SETC = 3;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_BLANK = 2'd2
    } line_state_t;

    typedef struct packed {
        logic hblank;
        logic hsync;
        logic midline;
        logic line_start;
    } line_out_t;
endpackage

// File: rtl/hline_wr_port.sv
`timescale 1ns/1ps
module hline_wr_port #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr_load,
    input  logic [PTR_W-1:0] wr_addr_val,
    output logic [PTR_W-1:0] wr_idx
);
    logic [PTR_W-1:0] addr_q;

    // a load in the same cycle redirects the write
    assign wr_idx = wr_addr_load ? wr_addr_val : addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (wr_en) begin
            addr_q <= wr_idx + 1'b1;
        end else if (wr_addr_load) begin
            addr_q <= wr_addr_val;
        end
    end
endmodule

// File: rtl/hline_flag_ram.sv
`timescale 1ns/1ps
module hline_flag_ram
    import hline_ctrl_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [FLAG_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [FLAG_W-1:0] rd_flags
);
    localparam int DEPTH = 1 << PTR_W;

    logic [FLAG_W-1:0] mem [DEPTH];

    assign rd_flags = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/hline_line_fsm.sv
`timescale 1ns/1ps
module hline_line_fsm
    import hline_ctrl_pkg::*;
#(
    parameter int              PTR_W       = 8,
    parameter logic [PTR_W-1:0] RESTART_PTR = 8'h68
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              force_blank,
    input  logic [FLAG_W-1:0] rd_flags,
    output logic [PTR_W-1:0]  rd_ptr,
    output line_out_t         outs
);
    line_state_t      state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    line_out_t        outs_d;

    assign rd_ptr = ptr_q;

    // next state, pointer and output decode
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q + 1'b1;
        outs_d  = '0;
        unique case (state_q)
            ST_HOLD: begin
                ptr_d = RESTART_PTR;
                if (force_blank) begin
                    outs_d.hblank = 1'b1;
                end else begin
                    state_d           = ST_SCAN;   // T_RELEASE
                    outs_d.line_start = 1'b1;
                end
            end
            ST_SCAN: begin
                outs_d.midline = rd_flags[BIT_MID];
                if (rd_flags[BIT_SETC]) begin
                    state_d       = ST_BLANK;      // T_SETC
                    outs_d.hblank = 1'b1;
                    outs_d.hsync  = rd_flags[BIT_SYNC];
                end
            end
            ST_BLANK: begin
                outs_d.midline = rd_flags[BIT_MID];
                outs_d.hblank  = 1'b1;
                outs_d.hsync   = rd_flags[BIT_SYNC];
                if (rd_flags[BIT_SWT]) begin
                    state_d           = ST_SCAN;   // T_SWITCH
                    ptr_d             = RESTART_PTR;
                    outs_d.line_start = 1'b1;
                end
            end
            default: begin
                state_d = ST_HOLD;
                ptr_d   = RESTART_PTR;
                outs_d.hblank = 1'b1;
            end
        endcase
        if (force_blank && state_q != ST_HOLD) begin
            state_d = ST_HOLD;                     // T_FORCE
            ptr_d   = RESTART_PTR;
            outs_d  = '0;
            outs_d.hblank = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            ptr_q   <= RESTART_PTR;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            outs <= '{hblank: 1'b1, hsync: 1'b0, midline: 1'b0, line_start: 1'b0};
        end else begin
            outs <= outs_d;
        end
    end
endmodule

// File: rtl/hline_ctrl_seq.sv
`timescale 1ns/1ps
module hline_ctrl_seq
    import hline_ctrl_pkg::*;
#(
    parameter int               PTR_W       = 8,
    parameter logic [PTR_W-1:0] RESTART_PTR = 8'h68
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             force_blank,
    input  logic             wr_en,
    input  logic             wr_addr_load,
    input  logic [PTR_W-1:0] wr_addr_val,
    input  logic [3:0]       wr_data,
    output logic             hblank,
    output logic             hsync,
    output logic             midline,
    output logic             line_start
);
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  rd_ptr;
    logic [FLAG_W-1:0] rd_flags;
    line_out_t         outs;

    hline_wr_port #(.PTR_W(PTR_W)) u_wr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr_load(wr_addr_load),
        .wr_addr_val(wr_addr_val), .wr_idx(wr_idx)
    );

    hline_flag_ram #(.PTR_W(PTR_W)) u_ram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_ptr(rd_ptr), .rd_flags(rd_flags)
    );

    hline_line_fsm #(.PTR_W(PTR_W), .RESTART_PTR(RESTART_PTR)) u_fsm (
        .clk(clk), .rst(rst), .force_blank(force_blank),
        .rd_flags(rd_flags), .rd_ptr(rd_ptr), .outs(outs)
    );

    assign hblank     = outs.hblank;
    assign hsync      = outs.hsync;
    assign midline    = outs.midline;
    assign line_start = outs.line_start;
endmodule

// File: rtl/hline_ctrl_seq_chk.sv
`timescale 1ns/1ps
module hline_ctrl_seq_chk (
    input logic clk,
    input logic rst,
    input logic force_blank,
    input logic hblank,
    input logic hsync,
    input logic midline,
    input logic line_start
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (hblank && !hsync && !midline && !line_start));

    // R9
    sync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        hsync |-> hblank);

    // R3
    force_hold_chk: assert property (@(posedge clk) disable iff (rst)
        force_blank |=> (hblank && !hsync && !midline && !line_start));

    // R4
    release_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(force_blank) |=> line_start);

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);

    // R7
    unblank_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hblank) |-> (line_start || $past(line_start)));
endmodule

bind hline_ctrl_seq hline_ctrl_seq_chk u_chk (
    .clk(clk), .rst(rst), .force_blank(force_blank), .hblank(hblank),
    .hsync(hsync), .midline(midline), .line_start(line_start)
);

// File: tb/hline_ctrl_seq_bench.sv
`timescale 1ns/1ps
module hline_ctrl_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       force_blank = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr_load = 1'b0;
    logic [7:0] wr_addr_val = '0;
    logic [3:0] wr_data = '0;
    logic       hblank, hsync, midline, line_start;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hline_ctrl_seq u_hline_ctrl_seq (
        .clk(clk), .rst(rst), .force_blank(force_blank), .wr_en(wr_en),
        .wr_addr_load(wr_addr_load), .wr_addr_val(wr_addr_val),
        .wr_data(wr_data), .hblank(hblank), .hsync(hsync),
        .midline(midline), .line_start(line_start)
    );

    // stimulus vectors: {load, addr, data}
    localparam logic [12:0] WR_VEC [7] = '{
        {1'b1, 8'h70, 4'h1},   // R10 mid-line marker
        {1'b1, 8'h78, 4'h8},   // R6 start blanking
        {1'b1, 8'h7A, 4'h4},   // R9 sync
        {1'b0, 8'h00, 4'h4},   // R2 increment to 0x7B
        {1'b0, 8'h00, 4'h2},   // R7 restart at 0x7C
        {1'b1, 8'h6C, 4'h2},   // R8 restart while visible
        {1'b1, 8'h6E, 4'h4}    // R9 sync while visible
    };

    // expected {hblank,hsync,midline,line_start} after edge n (n=1..21)
    localparam logic [3:0] EXP_LINE [21] = '{
        4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
        4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
        4'b0000, 4'b0000, 4'b1000, 4'b1000, 4'b1100, 4'b1100, 4'b1001
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] got;
        got = {hblank, hsync, midline, line_start};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (hblank,hsync,mid,start) at %0t",
                     req, got, exp, $time);
        end
    endtask

    task automatic write(input logic ld, input logic [7:0] a, input logic [3:0] d);
        wr_en = 1'b1;
        wr_addr_load = ld;
        wr_addr_val = a;
        wr_data = d;
        step();
        wr_en = 1'b0;
        wr_addr_load = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        check("R1 reset outputs", 4'b1000);
        rst = 1'b0;

        // load the first table while blanking is forced
        foreach (WR_VEC[i]) begin
            write(WR_VEC[i][12], WR_VEC[i][11:4], WR_VEC[i][3:0]);
        end
        check("R3 forced during load", 4'b1000);

        // release and walk three lines
        force_blank = 1'b0;
        step();
        check("R4 release start", 4'b0001);
        for (int n = 1; n <= 63; n++) begin
            step();
            // R5 R6 R7 R8 R9 R10 per-edge line table
            check("R5-line-table", EXP_LINE[(n - 1) % 21]);
        end

        // force blanking mid-line
        force_blank = 1'b1;
        step();
        check("R3 force mid-line", 4'b1000);
        for (int n = 0; n < 25; n++) begin
            step();
            check("R3 held", 4'b1000);
        end
        force_blank = 1'b0;
        step();
        check("R4 re-release", 4'b0001);
        for (int n = 1; n <= 9; n++) begin
            step();
        end
        check("R10 midline after restart", 4'b0010);
        step();
        check("R10 single pulse", 4'b0000);

        // reset clears table and write address; wrap tests
        rst = 1'b1;
        force_blank = 1'b1;
        step();
        check("R1 reset mid-run", 4'b1000);
        rst = 1'b0;
        write(1'b0, 8'h00, 4'h4);   // R1 address 0 after reset
        write(1'b0, 8'h00, 4'h4);   // 0x01
        write(1'b0, 8'h00, 4'h2);   // 0x02
        write(1'b1, 8'hFE, 4'h0);   // 0xFE
        write(1'b0, 8'h00, 4'h0);   // 0xFF
        write(1'b0, 8'h00, 4'h8);   // R2 wraps to 0x00
        force_blank = 1'b0;
        step();
        check("R4 release after reset", 4'b0001);
        for (int n = 1; n <= 152; n++) begin
            step();
            check("R1 cleared table", 4'b0000);
        end
        step();
        check("R2 wrapped write start blank", 4'b1000);
        step();
        check("R5 pointer wrap sync", 4'b1100);
        step();
        check("R7 restart after wrap", 4'b1001);
        step();
        check("R7 visible after restart", 4'b0000);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule